// File: doc/BRIEF.md
# Parallel Port Extended-Mode Negotiation Sequencer

This block is the host side of the handshake that moves a bidirectional parallel-port peripheral out of compatibility mode into an extended mode. A one-cycle start pulse latches an 8-bit extensibility request. The block then steps the host control lines through a fixed series of events. It places the request byte on the data bus, strobes it, and watches the peripheral's status lines for the two expected replies.

Every delay is a whole number of clock cycles set by a parameter. This covers the settle delays, the strobe width and the peripheral response window. The status inputs must already be synchronous to the block clock.

The outcome is reported on three outputs:
- A connected flag.
- A 3-bit phase code.
- A failure flag.

Each of the two timeouts leaves the lines in a defined recovery state.

Top module: `pp_negotiator`

## Requirements
- R1: After reset the outputs hold these values: SelectIn=0, HostBusy=1, nStrobe=1, nReverseReq=1, DIR=0, IRQEN=0, data=0x00, connected=0, fail=0, phase=4.
- R2: A start pulse seen while idle has these effects at that clock edge (edge 0): it latches the request byte and clears connected and fail. It drives SelectIn=0, HostBusy=1, nReverseReq=1, DIR=0, IRQEN=0 and nStrobe=1, and these lines stay so through two SETTLE_CYC periods.
- R3: From edge 2*SETTLE_CYC the data bus shows the latched request byte, and it keeps that value until the next accepted start.
- R4: At edge 3*SETTLE_CYC SelectIn goes to 1 and HostBusy goes to 0, with nStrobe=1 (event 1).
- R5: After event 1 the status lines are sampled on each of the next RESP_CYC edges. The first edge that sees ptr_clk=0, ack_data_req=1, xflag=1 and n_data_avail=1 drives nStrobe=0 (HostBusy stays 0).
- R6: nStrobe stays 0 for exactly STROBE_CYC cycles. nStrobe and HostBusy then both go to 1 at the same edge.
- R7: Suppose none of the RESP_CYC edges after event 1 matches. At the last of them the block drives SelectIn=0 and HostBusy=1, sets phase=0, connected=0 and fail=1, and returns to idle.
- R8: After the strobe, only ptr_clk=1 is required within RESP_CYC edges. ack_data_req, xflag and n_data_avail have no effect on the outcome.
- R9: If ptr_clk=1 is not seen within RESP_CYC edges after the strobe, the block drives SelectIn=0 at the last of them and sets phase=0, connected=0 and fail=1. HostBusy and nStrobe stay at 1.
- R10: Success is reached SETTLE_CYC cycles after the edge that saw ptr_clk=1. At that edge connected=1, fail=0 and phase=1, while SelectIn, HostBusy and nStrobe all stay at 1.
- R11: A start pulse while a sequence runs is ignored. It changes neither the timing nor the byte on the data bus.
- R12: The phase codes are: 0 unknown, 1 negotiation, 2 reverse idle, 3 reverse transfer, 4 terminated. The phase keeps its previous value until a sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin negotiation |
| ext_byte_i | input | 8 | Extensibility request byte |
| ptr_clk_i | input | 1 | Peripheral clock status line (synchronous) |
| ack_data_req_i | input | 1 | Acknowledge/data-request status line |
| xflag_i | input | 1 | Extension flag status line |
| n_data_avail_i | input | 1 | Active-low data-available status line |
| select_in_o | output | 1 | SelectIn control line |
| host_busy_o | output | 1 | HostBusy control line |
| n_strobe_o | output | 1 | Active-low strobe control line |
| n_rev_req_o | output | 1 | Active-low reverse-request control line |
| dir_o | output | 1 | Data direction control |
| irq_en_o | output | 1 | Interrupt enable control |
| data_o | output | 8 | Host data bus |
| connected_o | output | 1 | Negotiation succeeded |
| phase_o | output | 3 | Phase code (R12) |
| fail_o | output | 1 | Last negotiation failed |

## Verification
The assertions assume four things:
- The status inputs change only between clock edges.
- They are never X once reset is released.
- Start is a single-cycle pulse.
- The delay parameters are at least one.

The bench drives each status line at the falling edge, so each value is seen whole at one rising edge. It sweeps all sixteen event-2 patterns, every reply delay on either side of the response window for both waits, and all eight values of the ignored lines at the second wait. A start pulse carrying a different byte is placed in the middle of a sequence.

// File: rtl/pp_neg_pkg.sv
package pp_neg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_UNKNOWN    = 3'd0,
        PH_NEGOTIATE  = 3'd1,
        PH_REV_IDLE   = 3'd2,
        PH_REV_XFER   = 3'd3,
        PH_TERMINATED = 3'd4
    } phase_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PREP,
        SQ_PRE0,
        SQ_EV0,
        SQ_WAIT_RSP,
        SQ_STROBE,
        SQ_WAIT_CLK,
        SQ_POST
    } seq_t;

    typedef struct packed {
        logic sel;
        logic busy;
        logic strobe_n;
        logic revreq_n;
        logic dir;
        logic irq;
    } lines_t;

    typedef struct packed {
        seq_t              seq;
        lines_t            ln;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ext;
        logic              conn;
        logic              fail;
        phase_t            phase;
    } neg_st_t;

endpackage

// File: rtl/pp_neg_timer.sv
module pp_neg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pp_neg_match.sv
module pp_neg_match (
    input  logic ptr_clk_i,
    input  logic ack_data_req_i,
    input  logic xflag_i,
    input  logic n_data_avail_i,
    output logic rsp_ok_o,
    output logic clk_hi_o
);
    // First reply: clock low, the other three lines high.
    assign rsp_ok_o = !ptr_clk_i && ack_data_req_i && xflag_i && n_data_avail_i;
    // Second reply: clock high only; other levels are protocol dependent.
    assign clk_hi_o = ptr_clk_i;
endmodule

// File: rtl/pp_negotiator.sv
module pp_negotiator
    import pp_neg_pkg::*;
#(
    parameter int SETTLE_CYC = 400,
    parameter int STROBE_CYC = 100,
    parameter int RESP_CYC   = 7_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] ext_byte_i,
    input  logic              ptr_clk_i,
    input  logic              ack_data_req_i,
    input  logic              xflag_i,
    input  logic              n_data_avail_i,
    output logic              select_in_o,
    output logic              host_busy_o,
    output logic              n_strobe_o,
    output logic              n_rev_req_o,
    output logic              dir_o,
    output logic              irq_en_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              connected_o,
    output logic [2:0]        phase_o,
    output logic              fail_o
);
    localparam int MAX_A = (SETTLE_CYC > STROBE_CYC) ? SETTLE_CYC : STROBE_CYC;
    localparam int MAXC  = (MAX_A > RESP_CYC) ? MAX_A : RESP_CYC;
    localparam int CW    = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SET_L = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] STB_L = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] RSP_L = CW'(RESP_CYC - 1);

    neg_st_t       q, d;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          expired, rsp_ok, clk_hi;

    pp_neg_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ld),
        .load_val_i(ld_val),
        .expired_o (expired)
    );

    pp_neg_match u_match (
        .ptr_clk_i     (ptr_clk_i),
        .ack_data_req_i(ack_data_req_i),
        .xflag_i       (xflag_i),
        .n_data_avail_i(n_data_avail_i),
        .rsp_ok_o      (rsp_ok),
        .clk_hi_o      (clk_hi)
    );

    always_comb begin
        d      = q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (q.seq)
            SQ_IDLE: if (start_i) begin
                d.seq         = SQ_PREP;
                d.ext         = ext_byte_i;
                d.conn        = 1'b0;
                d.fail        = 1'b0;
                d.ln.sel      = 1'b0;
                d.ln.busy     = 1'b1;
                d.ln.revreq_n = 1'b1;
                ld            = 1'b1;
                ld_val        = SET_L;
            end
            SQ_PREP: if (expired) begin
                d.seq         = SQ_PRE0;
                d.ln.dir      = 1'b0;
                d.ln.irq      = 1'b0;
                d.ln.strobe_n = 1'b1;
                ld            = 1'b1;
                ld_val        = SET_L;
            end
            SQ_PRE0: if (expired) begin
                d.seq  = SQ_EV0;
                d.data = q.ext;
                ld     = 1'b1;
                ld_val = SET_L;
            end
            SQ_EV0: if (expired) begin
                d.seq         = SQ_WAIT_RSP;
                d.ln.sel      = 1'b1;
                d.ln.busy     = 1'b0;
                d.ln.strobe_n = 1'b1;
                ld            = 1'b1;
                ld_val        = RSP_L;
            end
            SQ_WAIT_RSP: begin
                if (rsp_ok) begin
                    d.seq         = SQ_STROBE;
                    d.ln.strobe_n = 1'b0;
                    d.ln.busy     = 1'b0;
                    ld            = 1'b1;
                    ld_val        = STB_L;
                end else if (expired) begin
                    d.seq     = SQ_IDLE;
                    d.ln.sel  = 1'b0;
                    d.ln.busy = 1'b1;
                    d.phase   = PH_UNKNOWN;
                    d.conn    = 1'b0;
                    d.fail    = 1'b1;
                end
            end
            SQ_STROBE: if (expired) begin
                d.seq         = SQ_WAIT_CLK;
                d.ln.strobe_n = 1'b1;
                d.ln.busy     = 1'b1;
                ld            = 1'b1;
                ld_val        = RSP_L;
            end
            SQ_WAIT_CLK: begin
                if (clk_hi) begin
                    d.seq  = SQ_POST;
                    ld     = 1'b1;
                    ld_val = SET_L;
                end else if (expired) begin
                    d.seq    = SQ_IDLE;
                    d.ln.sel = 1'b0;
                    d.phase  = PH_UNKNOWN;
                    d.conn   = 1'b0;
                    d.fail   = 1'b1;
                end
            end
            SQ_POST: if (expired) begin
                d.seq   = SQ_IDLE;
                d.conn  = 1'b1;
                d.phase = PH_NEGOTIATE;
            end
            default: d.seq = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.seq         <= SQ_IDLE;
            q.ln.sel      <= 1'b0;
            q.ln.busy     <= 1'b1;
            q.ln.strobe_n <= 1'b1;
            q.ln.revreq_n <= 1'b1;
            q.ln.dir      <= 1'b0;
            q.ln.irq      <= 1'b0;
            q.data        <= '0;
            q.ext         <= '0;
            q.conn        <= 1'b0;
            q.fail        <= 1'b0;
            q.phase       <= PH_TERMINATED;
        end else begin
            q <= d;
        end
    end

    assign select_in_o = q.ln.sel;
    assign host_busy_o = q.ln.busy;
    assign n_strobe_o  = q.ln.strobe_n;
    assign n_rev_req_o = q.ln.revreq_n;
    assign dir_o       = q.ln.dir;
    assign irq_en_o    = q.ln.irq;
    assign data_o      = q.data;
    assign connected_o = q.conn;
    assign phase_o     = q.phase;
    assign fail_o      = q.fail;

    // Strobe-width observer for the R6 property.
    logic [CW-1:0] low_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           low_cnt_q <= '0;
        else if (!n_strobe_o) low_cnt_q <= low_cnt_q + 1'b1;
        else                  low_cnt_q <= '0;
    end

    a_r4_sel_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(select_in_o) |-> (!host_busy_o && n_strobe_o));
    a_r5_strobe_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(n_strobe_o) |-> $past(rsp_ok));
    a_r6_strobe_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        !n_strobe_o |-> !host_busy_o);
    a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(n_strobe_o) |-> (low_cnt_q == CW'(STROBE_CYC) && host_busy_o));
    a_r7_fail_lines: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (!select_in_o && host_busy_o && !connected_o && phase_o == PH_UNKNOWN));
    a_r10_connect_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connected_o) |-> (phase_o == PH_NEGOTIATE && select_in_o && host_busy_o && n_strobe_o && !fail_o));
    a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.seq != SQ_IDLE) |=> $stable(q.ext));
    a_r12_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (q.seq != SQ_IDLE && $past(q.seq) != SQ_IDLE) |-> $stable(phase_o));
endmodule

// File: tb/pp_negotiator_tb.sv
`timescale 1ns/1ps
module pp_negotiator_tb;
    localparam int S = 4;
    localparam int T = 3;
    localparam int R = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] ext_byte = 8'h00;
    logic [3:0] st_in = 4'b1000;  // {ptr_clk, ack_data_req, xflag, n_data_avail}
    logic       sel, busy, stb, nrev, dir, irq, con, fl;
    logic [7:0] data;
    logic [2:0] ph;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] prev_data = 8'h00;
    logic [2:0] prev_phase = 3'd4;

    always #2.5 clk = ~clk;

    pp_negotiator #(.SETTLE_CYC(S), .STROBE_CYC(T), .RESP_CYC(R)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ext_byte_i(ext_byte),
        .ptr_clk_i(st_in[3]), .ack_data_req_i(st_in[2]), .xflag_i(st_in[1]),
        .n_data_avail_i(st_in[0]),
        .select_in_o(sel), .host_busy_o(busy), .n_strobe_o(stb), .n_rev_req_o(nrev),
        .dir_o(dir), .irq_en_o(irq), .data_o(data), .connected_o(con),
        .phase_o(ph), .fail_o(fl)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run(input logic [3:0] pat, input int d2, input int d56,
                       input logic [2:0] o56, input logic [7:0] ext, input bit ign);
        bit ok2, ok5, succ;
        int m, p, e;
        logic esel, ebusy, estb, econ, efl;
        logic [2:0] eph;
        logic [7:0] edat;
        string tl, ts;
        ok2 = (pat == 4'b0111) && (d2 <= R - 1);
        m   = 3*S + 1 + d2;
        ok5 = ok2 && (d56 <= R - 1);
        p   = m + T + 1 + d56;
        succ = ok5;
        e   = !ok2 ? 3*S + R : (!ok5 ? m + T + R : p + S);
        @(negedge clk);
        start = 1'b1; ext_byte = ext; st_in = 4'b1000;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= e + 2; k++) begin
            esel  = (k >= 3*S) && !(!succ && k >= e);
            if (k < 3*S)   ebusy = 1'b1;
            else if (!ok2) ebusy = (k >= e);
            else           ebusy = (k >= m + T);
            estb  = !(ok2 && k >= m && k < m + T);
            edat  = (k >= 2*S) ? ext : prev_data;
            econ  = succ && k >= e;
            efl   = !succ && k >= e;
            eph   = (k >= e) ? (succ ? 3'd1 : 3'd0) : prev_phase;
            if (k < 3*S)                             tl = "R2";
            else if (k == 3*S)                       tl = "R4";
            else if (k >= e)                         tl = succ ? "R10" : (ok2 ? "R9" : "R7");
            else if (ok2 && k >= m && k <= m + T)    tl = "R6";
            else if (ok2 && k > m + T)               tl = "R8";
            else                                     tl = "R5";
            if (ign) tl = "R11";
            ts = (k >= e) ? (succ ? "R10" : (ok2 ? "R9" : "R7")) : "R12";
            check(tl, {10'd0, sel, busy, stb, nrev, dir, irq},
                      {10'd0, esel, ebusy, estb, 1'b1, 1'b0, 1'b0});
            check(ign ? "R11" : "R3", {8'd0, data}, {8'd0, edat});
            check(ts, {11'd0, con, fl, ph}, {11'd0, econ, efl, eph});
            if (ign && k == S + 1) begin
                start = 1'b1; ext_byte = ~ext;
            end else begin
                start = 1'b0;
            end
            if (k < 3*S + d2)                  st_in = 4'b1000;
            else if (!ok2 || k < m + T + d56)  st_in = pat;
            else                               st_in = {1'b1, o56};
            @(negedge clk);
        end
        st_in = 4'b1000;
        ext_byte = 8'h00;
        prev_data  = ext;
        prev_phase = succ ? 3'd1 : 3'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset levels
        check("R1", {10'd0, sel, busy, stb, nrev, dir, irq}, 16'b000000_0000_011100);
        check("R1", {8'd0, data}, 16'h0000);
        check("R1", {11'd0, con, fl, ph}, {11'd0, 1'b0, 1'b0, 3'd4});
        // R5/R7: every event-2 pattern, only 0111 proceeds
        for (int pt = 0; pt < 16; pt++)
            run(4'(pt), 1, 1, 3'(pt), 8'(8'h30 + pt), 1'b0);
        // R5/R7: reply delay around the response window
        for (int dd = 0; dd <= R + 1; dd++)
            run(4'b0111, dd, 2, 3'b000, 8'(8'hA0 + dd), 1'b0);
        // R8/R9: clock reply delay around the window
        for (int dd = 0; dd <= R + 1; dd++)
            run(4'b0111, 0, dd, 3'b101, 8'(8'hC0 + dd), 1'b0);
        // R8: other lines ignored at the second wait
        for (int o = 0; o < 8; o++)
            run(4'b0111, 2, 0, 3'(o), 8'(8'h55 ^ o), 1'b0);
        // R11: start during a sequence is ignored
        run(4'b0111, 1, 1, 3'b010, 8'h96, 1'b1);
        run(4'b0111, R, 0, 3'b000, 8'h69, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R11 act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule